// File: doc/BRIEF.md
# Carry and Zero Status Flags with Interrupt Shadow

This block keeps the two condition flags of a small 8-bit processor, carry (C) and zero (Z). Each is a single register bit that the instruction decoder updates from ALU results through separate load strobes. Carry also has dedicated force-high and force-low strobes. They exist because logical shifts take their shift-in bit from carry, and software needs a way to pick that bit without running an arithmetic instruction. Zero has no such strobes.

A one-entry shadow copy protects the flags across interrupt service. When the control sequencer enters its interrupt state, it pulses a save strobe that copies the present C and Z into the shadow. When an interrupt return that re-enables interrupts executes, a restore strobe writes the shadow back over the live flags. An ordinary subroutine return pulses nothing, so the flags stay as they are. A parameter selects which of the two carry force strobes wins when both are asserted together; clear wins by default. Every update lands on a rising clock edge, and the outputs come straight from the flag registers.

Top module: `cz_flag_unit`

## Requirements
- R1: A synchronous active-high reset sets C, Z and both shadow bits to 0, so a restore issued right after reset yields C=0 and Z=0.
- R2: With only `ld_cy` asserted, C takes the value of `alu_cy` at the next rising edge. With only `ld_zr` asserted, Z takes the value of `alu_zr` at the next rising edge.
- R3: `set_cy` drives C to 1 at the next edge, overriding a simultaneous `ld_cy`.
- R4: `clr_cy` drives C to 0 at the next edge, overriding a simultaneous `ld_cy`. With the default parameter CLR_OVER_SET=1 it also overrides a simultaneous `set_cy`.
- R5: Z changes only through `ld_zr` or a restore. `set_cy` and `clr_cy` have no effect on Z.
- R6: `shd_save` copies the present C and Z into the shadow at the next edge. The save strobe by itself leaves the live flags unchanged.
- R7: `shd_restore` writes the shadow C and Z into the live flags at the next edge. It overrides any `ld_cy`, `ld_zr`, `set_cy` or `clr_cy` in the same cycle.
- R8: In a cycle with no strobe asserted, which is the case for an ordinary subroutine return, C and Z keep their values whatever the ALU inputs show.
- R9: When save and restore are asserted in the same cycle, the flags take the old shadow values and the shadow takes the old flag values. The two copies swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| alu_cy | input | 1 | Carry result from the ALU |
| alu_zr | input | 1 | Zero result from the ALU |
| ld_cy | input | 1 | Load C from `alu_cy` |
| ld_zr | input | 1 | Load Z from `alu_zr` |
| set_cy | input | 1 | Force C to 1 |
| clr_cy | input | 1 | Force C to 0 |
| shd_save | input | 1 | Copy C and Z into the shadow (interrupt entry) |
| shd_restore | input | 1 | Copy the shadow into C and Z (interrupt return, interrupts enabled) |
| cy_flag | output | 1 | Current carry flag |
| zr_flag | output | 1 | Current zero flag |

## Verification
The load path is tried with ALU values of both polarities on each flag separately. This shows whether the two load strobes are wired to the correct flag and whether C and Z are independent. Collision patterns assert set, clear, load and restore in the same cycle to expose any error in the priority order. They also pulse the carry force strobes while Z is 1, which shows whether those strobes leak into Z. The interrupt patterns save a known pair of values, overwrite the live flags, and then restore with conflicting strobes present. A final case with save and restore in one cycle separates a correct swap from a design that forwards the new flag values into the shadow.

// File: rtl/cz_flag_pkg.sv
package cz_flag_pkg;

   // one pair of condition bits, used for both the live and shadow copies
   typedef struct packed {
      logic cy;
      logic zr;
   } cz_pair_t;

   localparam cz_pair_t CZ_RESET = '{cy: 1'b0, zr: 1'b0};

endpackage

// File: rtl/cz_carry_cell.sv
module cz_carry_cell #(
   parameter int CLR_OVER_SET = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic alu_cy,
   input  logic ld_cy,
   input  logic set_cy,
   input  logic clr_cy,
   input  logic restore,
   input  logic shadow_cy,
   output logic cy_q
);

   logic force_en;
   logic force_val;
   logic cy_d;

   initial begin
      if (CLR_OVER_SET != 0 && CLR_OVER_SET != 1)
         $error("cz_carry_cell: CLR_OVER_SET must be 0 or 1");
   end

   generate
      if (CLR_OVER_SET == 1) begin : g_clr_wins
         always_comb begin
            force_en  = set_cy | clr_cy;
            force_val = ~clr_cy;
         end
      end else begin : g_set_wins
         always_comb begin
            force_en  = set_cy | clr_cy;
            force_val = set_cy;
         end
      end
   endgenerate

   always_comb begin
      if (restore)       cy_d = shadow_cy;
      else if (force_en) cy_d = force_val;
      else if (ld_cy)    cy_d = alu_cy;
      else               cy_d = cy_q;
   end

   always_ff @(posedge clk) begin
      if (rst) cy_q <= 1'b0;
      else     cy_q <= cy_d;
   end

   // R3
   set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (set_cy && !restore && !(clr_cy && CLR_OVER_SET == 1)) |=> cy_q);

   // R4
   clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (clr_cy && !restore && !(set_cy && CLR_OVER_SET == 0)) |=> !cy_q);

   // R7
   cy_restore_chk: assert property (@(posedge clk) disable iff (rst)
      restore |=> (cy_q == $past(shadow_cy)));

   // R8
   cy_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!restore && !set_cy && !clr_cy && !ld_cy) |=> $stable(cy_q));

endmodule

// File: rtl/cz_zero_cell.sv
module cz_zero_cell (
   input  logic clk,
   input  logic rst,
   input  logic alu_zr,
   input  logic ld_zr,
   input  logic restore,
   input  logic shadow_zr,
   output logic zr_q
);

   logic zr_d;

   always_comb begin
      if (restore)    zr_d = shadow_zr;
      else if (ld_zr) zr_d = alu_zr;
      else            zr_d = zr_q;
   end

   always_ff @(posedge clk) begin
      if (rst) zr_q <= 1'b0;
      else     zr_q <= zr_d;
   end

   // R2
   zr_load_chk: assert property (@(posedge clk) disable iff (rst)
      (ld_zr && !restore) |=> (zr_q == $past(alu_zr)));

   // R5
   zr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!ld_zr && !restore) |=> $stable(zr_q));

endmodule

// File: rtl/cz_shadow.sv
module cz_shadow
   import cz_flag_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  logic     save,
   input  cz_pair_t live,
   output cz_pair_t held
);

   always_ff @(posedge clk) begin
      if (rst)       held <= CZ_RESET;
      else if (save) held <= live;
   end

   // R6
   shadow_cap_chk: assert property (@(posedge clk) disable iff (rst)
      save |=> (held == $past(live)));

   // R6
   shadow_keep_chk: assert property (@(posedge clk) disable iff (rst)
      !save |=> $stable(held));

endmodule

// File: rtl/cz_flag_unit.sv
module cz_flag_unit
   import cz_flag_pkg::*;
#(
   parameter int CLR_OVER_SET = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic alu_cy,
   input  logic alu_zr,
   input  logic ld_cy,
   input  logic ld_zr,
   input  logic set_cy,
   input  logic clr_cy,
   input  logic shd_save,
   input  logic shd_restore,
   output logic cy_flag,
   output logic zr_flag
);

   cz_pair_t live_q;
   cz_pair_t shadow_q;

   cz_carry_cell #(.CLR_OVER_SET(CLR_OVER_SET)) u_cy (
      .clk       (clk),
      .rst       (rst),
      .alu_cy    (alu_cy),
      .ld_cy     (ld_cy),
      .set_cy    (set_cy),
      .clr_cy    (clr_cy),
      .restore   (shd_restore),
      .shadow_cy (shadow_q.cy),
      .cy_q      (live_q.cy)
   );

   cz_zero_cell u_zr (
      .clk       (clk),
      .rst       (rst),
      .alu_zr    (alu_zr),
      .ld_zr     (ld_zr),
      .restore   (shd_restore),
      .shadow_zr (shadow_q.zr),
      .zr_q      (live_q.zr)
   );

   cz_shadow u_shd (
      .clk  (clk),
      .rst  (rst),
      .save (shd_save),
      .live (live_q),
      .held (shadow_q)
   );

   assign cy_flag = live_q.cy;
   assign zr_flag = live_q.zr;

   // R9
   swap_chk: assert property (@(posedge clk) disable iff (rst)
      (shd_save && shd_restore) |=> (shadow_q == $past(live_q) && live_q == $past(shadow_q)));

   // R1
   reset_chk: assert property (@(posedge clk)
      rst |=> (live_q == CZ_RESET && shadow_q == CZ_RESET));

endmodule

// File: tb/sim_cz_flag_unit.sv
module sim_cz_flag_unit;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic alu_cy = 1'b0, alu_zr = 1'b0;
   logic ld_cy = 1'b0, ld_zr = 1'b0, set_cy = 1'b0, clr_cy = 1'b0;
   logic shd_save = 1'b0, shd_restore = 1'b0;
   logic cy_flag, zr_flag;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   cz_flag_unit u0 (
      .clk(clk), .rst(rst), .alu_cy(alu_cy), .alu_zr(alu_zr),
      .ld_cy(ld_cy), .ld_zr(ld_zr), .set_cy(set_cy), .clr_cy(clr_cy),
      .shd_save(shd_save), .shd_restore(shd_restore),
      .cy_flag(cy_flag), .zr_flag(zr_flag)
   );

   task automatic check(input string tag, input logic c_exp, input logic z_exp);
      n_chk++;
      if (cy_flag !== c_exp || zr_flag !== z_exp) begin
         n_bad++;
         $display("FAIL %s: C/Z got %b%b expected %b%b", tag, cy_flag, zr_flag, c_exp, z_exp);
      end
   endtask

   // apply one cycle of strobes, let the edge happen, then release strobes
   task automatic step(input logic lc, input logic lz, input logic ac, input logic az,
                       input logic st, input logic cl, input logic sv, input logic rs);
      ld_cy = lc; ld_zr = lz; alu_cy = ac; alu_zr = az;
      set_cy = st; clr_cy = cl; shd_save = sv; shd_restore = rs;
      @(posedge clk); #1;
      ld_cy = 0; ld_zr = 0; set_cy = 0; clr_cy = 0; shd_save = 0; shd_restore = 0;
   endtask

   task automatic t_reset();
      rst = 1'b1;
      @(posedge clk); @(posedge clk); #1;
      rst = 1'b0;
      check("R1 flags after reset", 1'b0, 1'b0);
      step(1, 1, 1, 1, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0, 1);
      check("R1 shadow zero after reset", 1'b0, 1'b0);
   endtask

   task automatic t_alu_load();
      step(1, 1, 1, 1, 0, 0, 0, 0);
      check("R2 load both ones", 1'b1, 1'b1);
      step(1, 0, 0, 0, 0, 0, 0, 0);
      check("R2 load C only", 1'b0, 1'b1);
      step(0, 1, 1, 0, 0, 0, 0, 0);
      check("R2 load Z only", 1'b0, 1'b0);
   endtask

   task automatic t_set_clear();
      step(1, 0, 0, 0, 1, 0, 0, 0);
      check("R3 set beats load", 1'b1, 1'b0);
      step(1, 0, 1, 0, 1, 1, 0, 0);
      check("R4 clear beats set and load", 1'b0, 1'b0);
      step(0, 0, 0, 0, 1, 0, 0, 0);
      step(0, 0, 0, 0, 0, 1, 0, 0);
      check("R4 clear alone", 1'b0, 1'b0);
   endtask

   task automatic t_zero_iso();
      step(0, 1, 0, 1, 0, 0, 0, 0);
      check("R5 Z loaded", 1'b0, 1'b1);
      step(0, 0, 0, 0, 1, 0, 0, 0);
      check("R5 set_cy leaves Z", 1'b1, 1'b1);
      step(0, 0, 0, 0, 0, 1, 0, 0);
      check("R5 clr_cy leaves Z", 1'b0, 1'b1);
   endtask

   task automatic t_save_restore();
      step(1, 1, 1, 1, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 1, 0);
      check("R6 save leaves flags", 1'b1, 1'b1);
      step(1, 1, 0, 0, 0, 0, 0, 0);
      check("R6 flags overwritten", 1'b0, 1'b0);
      step(1, 1, 0, 0, 0, 1, 0, 1);
      check("R7 restore beats clear and load", 1'b1, 1'b1);
   endtask

   task automatic t_hold();
      for (int i = 0; i < 4; i++) begin
         alu_cy = i[0]; alu_zr = ~i[0];
         @(posedge clk); #1;
         check("R8 no strobe holds", 1'b1, 1'b1);
      end
   endtask

   task automatic t_swap();
      step(1, 1, 0, 1, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 1, 0);
      step(1, 1, 1, 0, 0, 0, 0, 0);
      check("R9 pre-swap flags", 1'b1, 1'b0);
      step(0, 0, 0, 0, 0, 0, 1, 1);
      check("R9 flags take old shadow", 1'b0, 1'b1);
      step(0, 0, 0, 0, 0, 0, 0, 1);
      check("R9 shadow took old flags", 1'b1, 1'b0);
   endtask

   initial begin
      #400000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #1;
      t_reset();
      t_alu_load();
      t_set_clear();
      t_zero_iso();
      t_save_restore();
      t_hold();
      t_swap();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule